// File: doc/BRIEF.md
# Crosspoint Fast-Configuration Loader

This block fills the routing selectors of a crosspoint switch with a complete new configuration in one burst. When the load-mode input is high and LOAD rises, the loader fetches one 16-bit word per sequencing tick from an external configuration memory. It addresses that memory itself with a 2-bit word index. Bit n of every word belongs to output n, so four words build a 4-bit input selection for each of the sixteen outputs. The first word supplies the least significant select bit.

After the last word, the loader places the full 64-bit selection set on its pending output. In auto mode it then raises a configure pulse toward the switch core for one sequencing period. In the other mode it reports ready at once and leaves the core update to an external active-low CONFIGURE strobe. The sequencing clock is presented as `seq_tick`, a one-cycle strobe in the `clk` domain that marks each falling edge of that clock.

The memory word is taken on every `seq_tick` seen during a fetch. There is no back-pressure: the memory must present the addressed word by that tick. The switch core must accept the pending set on any cycle in which `core_cfg_pulse` is high.

Top module: `xbar_cfg_loader`

## Requirements
- R1: After reset, `ready` is 1, `ram_addr` is 0, `core_cfg_pulse` is 0 and `sel_pending` is all zero, which routes every output to input 0.
- R2: With `ld_mode` high, a rising edge of `load_in` sets `ready` to 0 and `ram_addr` to 0 on the next clock edge. A rising edge of `load_in` takes priority over a `seq_tick` in the same cycle.
- R3: During a fetch, each `seq_tick` advances `ram_addr` by one through 0, 1, 2 and 3. After the fourth word the address returns to 0.
- R4: `sel_pending[4n+b]` equals bit n of the word taken at address b. `sel_pending` changes only on the clock edge that takes the fourth word, and keeps its old value while a fetch is partly done.
- R5: With `auto_cfg` high, `core_cfg_pulse` is 1 and `ready` is 0 from the edge that takes the fourth word until the edge of the next `seq_tick`. At that edge the pulse drops and `ready` returns to 1.
- R6: With `auto_cfg` low, `ready` returns to 1 on the edge that takes the fourth word, and no internal configure pulse follows.
- R7: A falling edge of `cfg_strobe_n` raises `core_cfg_pulse` for exactly one clock cycle, starting in the cycle in which the strobe is first low.
- R8: `ram_addr_oe` is 1 exactly when `addr_en_n` is 0.
- R9: A new rising edge of `load_in` in the middle of a fetch restarts the fetch at address 0. Words taken before the restart have no effect on the next `sel_pending`.
- R10: With `ld_mode` low, `load_in` is ignored and no internal pulse is issued. If `ld_mode` falls during a fetch, the fetch is abandoned, `ready` returns to 1 and `sel_pending` is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_mode | input | 1 | High selects fast memory-driven configuration |
| load_in | input | 1 | Rising edge starts a fetch |
| seq_tick | input | 1 | One-cycle strobe per falling edge of the sequencing clock |
| auto_cfg | input | 1 | High: issue the configure pulse automatically |
| addr_en_n | input | 1 | Low enables the memory address drivers |
| cfg_strobe_n | input | 1 | External configure strobe, active low |
| word_in | input | 16 | Configuration word from memory |
| ram_addr | output | 2 | Memory word address |
| ram_addr_oe | output | 1 | Output enable for `ram_addr` |
| ready | output | 1 | High when idle or finished |
| sel_pending | output | 64 | Selection set, 4 bits per output, output n at bits 4n+3..4n |
| core_cfg_pulse | output | 1 | Configure request to the switch core |

## Verification
The bench checks bit order in `sel_pending`. A loader that shifts most-significant first, or mixes up which output a word bit feeds, produces a transposed or mirrored selection set that differs from the reference computed in the bench. It restarts a fetch after two words and checks that the earlier words leave no trace. It also applies a restart in the same cycle as a tick: a design that lets the tick win would start at address 1. It abandons a fetch by lowering `ld_mode` and holds the auto-mode pulse across several idle cycles before the closing tick. A loader that updates the pending set early, ends the pulse after one cycle, or reports ready too soon is caught by these checks.

// File: rtl/xbar_ldr_pkg.sv
package xbar_ldr_pkg;
  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_FETCH = 2'd1,
    LS_ARM   = 2'd2
  } ldr_state_e;
endpackage

// File: rtl/ldr_edge.sv
module ldr_edge #(
  parameter bit FALLING  = 1'b0,
  parameter bit IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LVL;
    else        prev_q <= sig;
  end

  generate
    if (FALLING) begin : g_fall
      assign evt = prev_q & ~sig;
    end else begin : g_rise
      assign evt = sig & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/ldr_seq.sv
module ldr_seq
  import xbar_ldr_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int AW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_mode,
  input  logic          start,
  input  logic          tick,
  input  logic          auto_cfg,
  output logic [AW-1:0] word_idx,
  output logic          ready,
  output logic          shift_en,
  output logic          commit,
  output logic          arm
);
  localparam logic [AW-1:0] LAST_IDX = AW'(N_WORDS - 1);

  ldr_state_e state_q;
  logic       last_word;

  assign last_word = (word_idx == LAST_IDX);
  assign shift_en  = ld_mode && !start && tick && (state_q == LS_FETCH);
  assign commit    = shift_en && last_word;
  assign arm       = (state_q == LS_ARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LS_IDLE;
      word_idx <= '0;
      ready    <= 1'b1;
    end else if (!ld_mode) begin
      state_q  <= LS_IDLE;
      word_idx <= '0;
      ready    <= 1'b1;
    end else if (start) begin
      state_q  <= LS_FETCH;
      word_idx <= '0;
      ready    <= 1'b0;
    end else begin
      case (state_q)
        LS_FETCH: begin
          if (shift_en) begin
            if (last_word) begin
              word_idx <= '0;
              if (auto_cfg) begin
                state_q <= LS_ARM;
                ready   <= 1'b0;
              end else begin
                state_q <= LS_IDLE;
                ready   <= 1'b1;
              end
            end else begin
              word_idx <= word_idx + 1'b1;
            end
          end
        end
        LS_ARM: begin
          if (tick) begin
            state_q <= LS_IDLE;
            ready   <= 1'b1;
          end
        end
        default: begin
          state_q <= LS_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ldr_slice.sv
module ldr_slice #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             commit,
  input  logic             bit_in,
  output logic [SEL_W-1:0] pending
);
  logic [SEL_W-1:0] stage_q;
  logic [SEL_W-1:0] stage_nx;

  assign stage_nx = {bit_in, stage_q[SEL_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      pending <= '0;
    end else begin
      if (shift_en) stage_q <= stage_nx;
      if (commit)   pending <= stage_nx;
    end
  end
endmodule

// File: rtl/xbar_cfg_loader.sv
module xbar_cfg_loader #(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = $clog2(N_PORTS),
  parameter int AW      = (SEL_W > 1) ? $clog2(SEL_W) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_mode,
  input  logic                     load_in,
  input  logic                     seq_tick,
  input  logic                     auto_cfg,
  input  logic                     addr_en_n,
  input  logic                     cfg_strobe_n,
  input  logic [N_PORTS-1:0]       word_in,
  output logic [AW-1:0]            ram_addr,
  output logic                     ram_addr_oe,
  output logic                     ready,
  output logic [N_PORTS*SEL_W-1:0] sel_pending,
  output logic                     core_cfg_pulse
);
  logic load_rise;
  logic strobe_fall;
  logic shift_en;
  logic commit;
  logic arm;

  ldr_edge #(.FALLING(1'b0), .IDLE_LVL(1'b0)) u_load_edge (
    .clk(clk), .rst_n(rst_n), .sig(load_in), .evt(load_rise)
  );

  ldr_edge #(.FALLING(1'b1), .IDLE_LVL(1'b1)) u_strobe_edge (
    .clk(clk), .rst_n(rst_n), .sig(cfg_strobe_n), .evt(strobe_fall)
  );

  ldr_seq #(.N_WORDS(SEL_W), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_mode  (ld_mode),
    .start    (load_rise),
    .tick     (seq_tick),
    .auto_cfg (auto_cfg),
    .word_idx (ram_addr),
    .ready    (ready),
    .shift_en (shift_en),
    .commit   (commit),
    .arm      (arm)
  );

  generate
    for (genvar n = 0; n < N_PORTS; n++) begin : g_slice
      ldr_slice #(.SEL_W(SEL_W)) u_slice (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .commit   (commit),
        .bit_in   (word_in[n]),
        .pending  (sel_pending[n*SEL_W +: SEL_W])
      );
    end
  endgenerate

  assign ram_addr_oe    = ~addr_en_n;
  assign core_cfg_pulse = arm | strobe_fall;
endmodule

// File: rtl/xbar_cfg_loader_chk.sv
module xbar_cfg_loader_chk #(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = 4,
  parameter int AW      = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ld_mode,
  input logic                     load_in,
  input logic                     seq_tick,
  input logic                     cfg_strobe_n,
  input logic [AW-1:0]            ram_addr,
  input logic                     ready,
  input logic [N_PORTS*SEL_W-1:0] sel_pending,
  input logic                     core_cfg_pulse
);
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mode && $rose(load_in)) |=> (!ready && ram_addr == '0)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mode && !ready && seq_tick && !$rose(load_in) && !core_cfg_pulse)
      |=> (ram_addr == AW'($past(ram_addr) + 1'b1))); // R3

  AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_tick |=> $stable(sel_pending)); // R4

  AST_INT_PULSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_cfg_pulse && cfg_strobe_n) |-> $past(ld_mode)); // R10

  AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(seq_tick) || !$past(ld_mode))); // R5
endmodule

bind xbar_cfg_loader xbar_cfg_loader_chk #(
  .N_PORTS(N_PORTS), .SEL_W(SEL_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_mode(ld_mode), .load_in(load_in),
  .seq_tick(seq_tick), .cfg_strobe_n(cfg_strobe_n), .ram_addr(ram_addr),
  .ready(ready), .sel_pending(sel_pending), .core_cfg_pulse(core_cfg_pulse)
);

// File: tb/xbar_cfg_loader_test.sv
module xbar_cfg_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_mode = 1'b1;
  logic        load_in = 1'b0;
  logic        seq_tick = 1'b0;
  logic        auto_cfg = 1'b0;
  logic        addr_en_n = 1'b0;
  logic        cfg_strobe_n = 1'b1;
  logic [15:0] word_in = '0;
  logic [1:0]  ram_addr;
  logic        ram_addr_oe;
  logic        ready;
  logic [63:0] sel_pending;
  logic        core_cfg_pulse;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] wv [4];
  logic [63:0] exp_pend = '0;

  always #5 clk = ~clk;

  xbar_cfg_loader uut (
    .clk(clk), .rst_n(rst_n), .ld_mode(ld_mode), .load_in(load_in),
    .seq_tick(seq_tick), .auto_cfg(auto_cfg), .addr_en_n(addr_en_n),
    .cfg_strobe_n(cfg_strobe_n), .word_in(word_in), .ram_addr(ram_addr),
    .ram_addr_oe(ram_addr_oe), .ready(ready), .sel_pending(sel_pending),
    .core_cfg_pulse(core_cfg_pulse)
  );

  function automatic logic [63:0] ref_sel(input logic [15:0] w0, input logic [15:0] w1,
                                          input logic [15:0] w2, input logic [15:0] w3);
    logic [63:0] e;
    for (int n = 0; n < 16; n++) begin
      e[n*4+0] = w0[n];
      e[n*4+1] = w1[n];
      e[n*4+2] = w2[n];
      e[n*4+3] = w3[n];
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_load();
    @(negedge clk); load_in = 1'b1;
    @(negedge clk); load_in = 1'b0;
  endtask

  task automatic tick_word(input logic [15:0] w);
    @(negedge clk); seq_tick = 1'b1; word_in = w;
    @(negedge clk); seq_tick = 1'b0;
  endtask

  task automatic full_fetch(input logic auto_m);
    auto_cfg = auto_m;
    pulse_load();
    chk("R2 ready low", {63'd0, ready}, 64'd0);
    chk("R2 addr zero", {62'd0, ram_addr}, 64'd0);
    for (int b = 0; b < 4; b++) begin
      wv[b] = 16'($urandom);
      chk("R3 addr step", {62'd0, ram_addr}, 64'(b));
      if (b == 3) chk("R4 pending held mid fetch", sel_pending, exp_pend);
      tick_word(wv[b]);
    end
    exp_pend = ref_sel(wv[0], wv[1], wv[2], wv[3]);
    chk("R4 pending mapping", sel_pending, exp_pend);
    chk("R3 addr wrap", {62'd0, ram_addr}, 64'd0);
    if (auto_m) begin
      chk("R5 pulse high", {63'd0, core_cfg_pulse}, 64'd1);
      chk("R5 ready low while armed", {63'd0, ready}, 64'd0);
      repeat (3) @(negedge clk);
      chk("R5 pulse held to next tick", {63'd0, core_cfg_pulse}, 64'd1);
      tick_word(16'hFFFF);
      chk("R5 pulse drops", {63'd0, core_cfg_pulse}, 64'd0);
      chk("R5 ready after pulse", {63'd0, ready}, 64'd1);
      chk("R5 closing tick ignored", sel_pending, exp_pend);
    end else begin
      chk("R6 ready at fourth word", {63'd0, ready}, 64'd1);
      chk("R6 no pulse", {63'd0, core_cfg_pulse}, 64'd0);
      tick_word(16'h1234);
      chk("R6 still no pulse", {63'd0, core_cfg_pulse}, 64'd0);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 ready", {63'd0, ready}, 64'd1);
    chk("R1 addr", {62'd0, ram_addr}, 64'd0);
    chk("R1 pulse", {63'd0, core_cfg_pulse}, 64'd0);
    chk("R1 pending", sel_pending, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 address enable
    addr_en_n = 1'b1; #1;
    chk("R8 oe off", {63'd0, ram_addr_oe}, 64'd0);
    addr_en_n = 1'b0; #1;
    chk("R8 oe on", {63'd0, ram_addr_oe}, 64'd1);

    // directed patterns through both modes
    full_fetch(1'b0);
    full_fetch(1'b1);

    // R7 external strobe
    @(negedge clk); cfg_strobe_n = 1'b0; #1;
    chk("R7 strobe pulse", {63'd0, core_cfg_pulse}, 64'd1);
    @(negedge clk);
    chk("R7 strobe one cycle", {63'd0, core_cfg_pulse}, 64'd0);
    cfg_strobe_n = 1'b1;

    // R9 restart mid fetch
    auto_cfg = 1'b0;
    pulse_load();
    tick_word(16'hAAAA);
    tick_word(16'h5555);
    chk("R9 addr before restart", {62'd0, ram_addr}, 64'd2);
    pulse_load();
    chk("R9 restart addr", {62'd0, ram_addr}, 64'd0);
    for (int b = 0; b < 4; b++) begin
      wv[b] = 16'($urandom);
      tick_word(wv[b]);
    end
    exp_pend = ref_sel(wv[0], wv[1], wv[2], wv[3]);
    chk("R9 partial words discarded", sel_pending, exp_pend);

    // R2 restart in same cycle as a tick: load wins
    pulse_load();
    tick_word(16'h0F0F);
    @(negedge clk); load_in = 1'b1; seq_tick = 1'b1; word_in = 16'hFFFF;
    @(negedge clk); load_in = 1'b0; seq_tick = 1'b0;
    chk("R2 load beats tick", {62'd0, ram_addr}, 64'd0);
    for (int b = 0; b < 4; b++) begin
      wv[b] = 16'($urandom);
      tick_word(wv[b]);
    end
    exp_pend = ref_sel(wv[0], wv[1], wv[2], wv[3]);
    chk("R2 after tie", sel_pending, exp_pend);

    // R10 ld_mode low ignores load, no pulse
    ld_mode = 1'b0; auto_cfg = 1'b1;
    pulse_load();
    chk("R10 load ignored", {63'd0, ready}, 64'd1);
    for (int b = 0; b < 4; b++) tick_word(16'hBEEF);
    chk("R10 no pulse", {63'd0, core_cfg_pulse}, 64'd0);
    chk("R10 pending kept", sel_pending, exp_pend);
    // R10 abort mid fetch
    ld_mode = 1'b1;
    pulse_load();
    tick_word(16'h1111);
    tick_word(16'h2222);
    @(negedge clk); ld_mode = 1'b0;
    @(negedge clk);
    chk("R10 abort ready", {63'd0, ready}, 64'd1);
    chk("R10 abort pending", sel_pending, exp_pend);
    ld_mode = 1'b1;

    // random runs
    for (int i = 0; i < 20; i++) full_fetch(1'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule